// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host bus and the write engine of a NOR-style flash controller. Each host write carries a command byte. Some commands act at once: they pick the read space, clear the sticky status flags, or ask the write engine to pause or continue. Other commands open a two-write sequence. For those, the second write supplies the confirm byte, the target address and the data. When the sequence is valid and the program/erase enable input allows it, the block sends a one-cycle start pulse to the write engine, together with an operation code, the address and the data.

Read cycles return data from one of four spaces: the array, the identifier codes, the query table, or the status byte. The read space is chosen by the last read-space command. A modifying sequence leaves the block in status reads. While the write engine reports busy, only data bit 7 is driven, and it shows "not ready". The status byte has these flags: ready, erase suspended, program suspended, erase failure, program failure, lockout violation and command-sequence error. The failure and violation flags stay set until the clear command is written.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the block reads the array space (`rd_data` equals `arr_rdata`). Status has only bit 7 set when the engine is idle. `op_start`, `susp_req` and `resume_req` are low.
- R2: A single write of FFh selects array reads, 90h selects identifier reads (`id_rdata`), 98h selects query reads (`qry_rdata`) and 70h selects status reads. Each choice takes effect from the cycle after the write.
- R3: A write of 50h clears status bits 5, 4, 3 and 1 in the next cycle, and leaves the read space unchanged. If an engine failure input is high in the same cycle as the 50h write, the failure bit is set.
- R4: The sequence 20h, then D0h, gives a one-cycle `op_start` in the cycle after the confirm write. It carries `op_code`=0 (erase) and `op_addr` taken from the confirm write. After the sequence the read space is status.
- R5: A write of 40h or 10h followed by any write starts `op_code`=1 (program). `op_addr` and `op_wdata` come from the second write.
- R6: After a first byte of 60h, a second byte of 01h starts `op_code`=5 (lock set) at the second-write address. D0h starts `op_code`=6 (lock clear). 03h starts `op_code`=7 (read configuration), with the configuration value on `op_addr`.
- R7: A first byte of E8h starts `op_code`=2 (buffered write), C0h starts `op_code`=3 (protection program), and B8h starts `op_code`=4 (configuration). In each case the address and data are taken from the second write.
- R8: A second byte that is not valid for its first byte does not start anything. This covers any byte other than D0h after 20h, and any byte other than 01h, D0h or 03h after 60h, including FFh. Instead it sets status bit 1 and selects status reads.
- R9: If `pe_en` is low on a valid second write, no operation starts, status bit 3 is set and status reads are selected. Read-space commands still work while `pe_en` is low.
- R10: While `wsm_busy` is high, `rd_oe` is 80h when `bus_rd` is high, and `rd_data[7]` is 0. When the engine is idle, `rd_oe` is FFh during a read. When `bus_rd` is low, `rd_oe` is 00h.
- R11: A write of B0h while `wsm_busy` is high gives a one-cycle `susp_req`. A write of D0h outside a sequence while `wsm_susp` is high gives a one-cycle `resume_req`. Both select status reads. D0h with no suspension and B0h with an idle engine issue no request.
- R12: Status bit 7 is the inverse of `wsm_busy`. Bit 6 is `wsm_susp` when the last started operation was an erase, and bit 2 is `wsm_susp` otherwise. Bits 5 and 4 latch the erase and program failure inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe, one command byte per cycle |
| bus_addr | input | AW | Host write address |
| bus_wdata | input | 8 | Host write data / command byte |
| bus_rd | input | 1 | Host read enable |
| pe_en | input | 1 | Program/erase enable level; low means lockout |
| arr_rdata | input | 8 | Array read data |
| id_rdata | input | 8 | Identifier read data |
| qry_rdata | input | 8 | Query read data |
| rd_data | output | 8 | Read data to host |
| rd_oe | output | 8 | Per-bit output enable for the read data |
| wsm_busy | input | 1 | Write engine busy |
| wsm_susp | input | 1 | Write engine suspended |
| wsm_erase_fail | input | 1 | Erase failure pulse from the engine |
| wsm_prog_fail | input | 1 | Program failure pulse from the engine |
| op_start | output | 1 | One-cycle operation start |
| op_code | output | 3 | Operation code, valid with `op_start` |
| op_addr | output | AW | Operation address |
| op_wdata | output | 8 | Operation data |
| susp_req | output | 1 | One-cycle suspend request |
| resume_req | output | 1 | One-cycle resume request |

## Verification
If the pending-first-byte register is wrong, it shows on the very next write. A valid confirm then produces no `op_start`, or a stray confirm starts an operation. Either way the error is visible one cycle after that write, through `op_start` and status bit 1. If the read-space register is wrong, the next read returns the wrong source. A stuck or dropped sticky flag shows in the status byte one cycle after the event or the clear. The bench reads status back to catch both. A wrong record of the last operation class makes the suspend flag appear in bit 2 instead of bit 6 as soon as the engine reports suspension.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int CMD_W = 8;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_CLEAR   = 8'h50;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_PROG_A  = 8'h40;
  localparam logic [7:0] C_PROG_B  = 8'h10;
  localparam logic [7:0] C_BUFWR   = 8'hE8;
  localparam logic [7:0] C_PROTECT = 8'hC0;
  localparam logic [7:0] C_CONFIG  = 8'hB8;
  localparam logic [7:0] C_LOCKGRP = 8'h60;
  localparam logic [7:0] C_SUSPEND = 8'hB0;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_LKSET2  = 8'h01;
  localparam logic [7:0] C_RDCFG2  = 8'h03;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_QUERY  = 2'd2,
    RM_STATUS = 2'd3
  } rmode_t;

  typedef enum logic [2:0] {
    OP_ERASE   = 3'd0,
    OP_PROG    = 3'd1,
    OP_BUFWR   = 3'd2,
    OP_PROTECT = 3'd3,
    OP_CONFIG  = 3'd4,
    OP_LKSET   = 3'd5,
    OP_LKCLR   = 3'd6,
    OP_RDCFG   = 3'd7
  } opcode_t;

  typedef struct packed {
    logic    ok;
    opcode_t op;
  } pair_t;

  function automatic logic needs_second(input logic [7:0] b);
    return (b == C_ERASE)  || (b == C_PROG_A)  || (b == C_PROG_B) ||
           (b == C_BUFWR)  || (b == C_PROTECT) || (b == C_CONFIG) ||
           (b == C_LOCKGRP);
  endfunction

  function automatic pair_t decode_pair(input logic [7:0] first,
                                        input logic [7:0] second);
    pair_t r;
    r.ok = 1'b0;
    r.op = OP_ERASE;
    case (first)
      C_ERASE: begin
        r.ok = (second == C_CONFIRM);
        r.op = OP_ERASE;
      end
      C_PROG_A, C_PROG_B: begin
        r.ok = 1'b1;
        r.op = OP_PROG;
      end
      C_BUFWR: begin
        r.ok = 1'b1;
        r.op = OP_BUFWR;
      end
      C_PROTECT: begin
        r.ok = 1'b1;
        r.op = OP_PROTECT;
      end
      C_CONFIG: begin
        r.ok = 1'b1;
        r.op = OP_CONFIG;
      end
      C_LOCKGRP: begin
        if (second == C_LKSET2) begin
          r.ok = 1'b1;
          r.op = OP_LKSET;
        end else if (second == C_CONFIRM) begin
          r.ok = 1'b1;
          r.op = OP_LKCLR;
        end else if (second == C_RDCFG2) begin
          r.ok = 1'b1;
          r.op = OP_RDCFG;
        end
      end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] pack_status(input logic ready,
                                             input logic esusp,
                                             input logic eerr,
                                             input logic perr,
                                             input logic lkerr,
                                             input logic psusp,
                                             input logic sqerr);
    return {ready, esusp, eerr, perr, lkerr, psusp, sqerr, 1'b0};
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          pe_en,
  input  logic          wsm_busy,
  input  logic          wsm_susp,
  output rmode_t        mode,
  output logic          op_start,
  output opcode_t       op_code,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_wdata,
  output logic          susp_req,
  output logic          resume_req,
  output logic          last_erase,
  output logic          ev_clear,
  output logic          ev_seq_err,
  output logic          ev_lock_err
);

  logic       pend, pend_n;
  logic [7:0] first, first_n;
  rmode_t     mode_n;
  logic       start_c, susp_c, res_c;
  opcode_t    code_c;
  pair_t      dec;

  always_comb begin
    pend_n      = pend;
    first_n     = first;
    mode_n      = mode;
    start_c     = 1'b0;
    code_c      = OP_ERASE;
    susp_c      = 1'b0;
    res_c       = 1'b0;
    ev_clear    = 1'b0;
    ev_seq_err  = 1'b0;
    ev_lock_err = 1'b0;
    dec         = decode_pair(first, bus_wdata);
    if (bus_wr) begin
      if (pend) begin
        pend_n = 1'b0;
        mode_n = RM_STATUS;
        if (!dec.ok) begin
          ev_seq_err = 1'b1;
        end else if (!pe_en) begin
          ev_lock_err = 1'b1;
        end else begin
          start_c = 1'b1;
          code_c  = dec.op;
        end
      end else if (needs_second(bus_wdata)) begin
        pend_n  = 1'b1;
        first_n = bus_wdata;
      end else begin
        case (bus_wdata)
          C_ARRAY:  mode_n = RM_ARRAY;
          C_IDENT:  mode_n = RM_IDENT;
          C_QUERY:  mode_n = RM_QUERY;
          C_STATUS: mode_n = RM_STATUS;
          C_CLEAR:  ev_clear = 1'b1;
          C_SUSPEND: begin
            mode_n = RM_STATUS;
            susp_c = wsm_busy;
          end
          C_CONFIRM: begin
            if (wsm_susp) begin
              mode_n = RM_STATUS;
              res_c  = 1'b1;
            end
          end
          default: mode_n = mode;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      first      <= 8'h00;
      mode       <= RM_ARRAY;
      op_start   <= 1'b0;
      op_code    <= OP_ERASE;
      op_addr    <= '0;
      op_wdata   <= 8'h00;
      susp_req   <= 1'b0;
      resume_req <= 1'b0;
      last_erase <= 1'b0;
    end else begin
      pend       <= pend_n;
      first      <= first_n;
      mode       <= mode_n;
      op_start   <= start_c;
      susp_req   <= susp_c;
      resume_req <= res_c;
      if (start_c) begin
        op_code    <= code_c;
        op_addr    <= bus_addr;
        op_wdata   <= bus_wdata;
        last_erase <= (code_c == OP_ERASE);
      end
    end
  end

endmodule

// File: rtl/fcd_status.sv
module fcd_status
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wsm_busy,
  input  logic       wsm_susp,
  input  logic       wsm_erase_fail,
  input  logic       wsm_prog_fail,
  input  logic       last_erase,
  input  logic       ev_clear,
  input  logic       ev_seq_err,
  input  logic       ev_lock_err,
  output logic [7:0] status
);

  logic eerr, perr, lkerr, sqerr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eerr  <= 1'b0;
      perr  <= 1'b0;
      lkerr <= 1'b0;
      sqerr <= 1'b0;
    end else begin
      eerr  <= wsm_erase_fail | (eerr  & ~ev_clear);
      perr  <= wsm_prog_fail  | (perr  & ~ev_clear);
      lkerr <= ev_lock_err    | (lkerr & ~ev_clear);
      sqerr <= ev_seq_err     | (sqerr & ~ev_clear);
    end
  end

  always_comb begin
    status = pack_status(~wsm_busy, wsm_susp & last_erase, eerr, perr,
                         lkerr, wsm_susp & ~last_erase, sqerr);
  end

endmodule

// File: rtl/fcd_rdmux.sv
module fcd_rdmux
  import fcd_pkg::*;
(
  input  rmode_t     mode,
  input  logic       bus_rd,
  input  logic       wsm_busy,
  input  logic [7:0] arr_rdata,
  input  logic [7:0] id_rdata,
  input  logic [7:0] qry_rdata,
  input  logic [7:0] status,
  output logic [7:0] rd_data,
  output logic [7:0] rd_oe
);

  logic [7:0] sel;

  always_comb begin
    case (mode)
      RM_ARRAY: sel = arr_rdata;
      RM_IDENT: sel = id_rdata;
      RM_QUERY: sel = qry_rdata;
      default:  sel = status;
    endcase
    if (wsm_busy) begin
      rd_data = {status[7], 7'b0};
      rd_oe   = bus_rd ? 8'h80 : 8'h00;
    end else begin
      rd_data = sel;
      rd_oe   = bus_rd ? 8'hFF : 8'h00;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_rd,
  input  logic          pe_en,
  input  logic [7:0]    arr_rdata,
  input  logic [7:0]    id_rdata,
  input  logic [7:0]    qry_rdata,
  output logic [7:0]    rd_data,
  output logic [7:0]    rd_oe,
  input  logic          wsm_busy,
  input  logic          wsm_susp,
  input  logic          wsm_erase_fail,
  input  logic          wsm_prog_fail,
  output logic          op_start,
  output logic [2:0]    op_code,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_wdata,
  output logic          susp_req,
  output logic          resume_req
);

  rmode_t     mode;
  opcode_t    code_q;
  logic       last_erase;
  logic       ev_clear, ev_seq_err, ev_lock_err;
  logic [7:0] status;

  fcd_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pe_en      (pe_en),
    .wsm_busy   (wsm_busy),
    .wsm_susp   (wsm_susp),
    .mode       (mode),
    .op_start   (op_start),
    .op_code    (code_q),
    .op_addr    (op_addr),
    .op_wdata   (op_wdata),
    .susp_req   (susp_req),
    .resume_req (resume_req),
    .last_erase (last_erase),
    .ev_clear   (ev_clear),
    .ev_seq_err (ev_seq_err),
    .ev_lock_err(ev_lock_err)
  );

  assign op_code = code_q;

  fcd_status u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .wsm_busy      (wsm_busy),
    .wsm_susp      (wsm_susp),
    .wsm_erase_fail(wsm_erase_fail),
    .wsm_prog_fail (wsm_prog_fail),
    .last_erase    (last_erase),
    .ev_clear      (ev_clear),
    .ev_seq_err    (ev_seq_err),
    .ev_lock_err   (ev_lock_err),
    .status        (status)
  );

  fcd_rdmux u_rdmux (
    .mode     (mode),
    .bus_rd   (bus_rd),
    .wsm_busy (wsm_busy),
    .arr_rdata(arr_rdata),
    .id_rdata (id_rdata),
    .qry_rdata(qry_rdata),
    .status   (status),
    .rd_data  (rd_data),
    .rd_oe    (rd_oe)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       pe_en,
  input logic       bus_rd,
  input logic       wsm_busy,
  input logic       wsm_erase_fail,
  input logic       wsm_prog_fail,
  input logic [7:0] rd_oe,
  input logic       op_start,
  input logic       susp_req,
  input logic       resume_req,
  input logic       ev_clear,
  input logic       ev_seq_err,
  input logic [7:0] status
);

  // R4: a start always follows a host write one cycle earlier
  a_r4_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(bus_wr));

  // R9: no start unless the enable level was high at the confirm write
  a_r9_no_start_locked: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(pe_en));

  // R10: while busy only bit 7 may be enabled
  a_r10_busy_oe: assert property (@(posedge clk) disable iff (!rst_n)
    wsm_busy |-> ((rd_oe & 8'h7F) == 8'h00));

  // R11: a suspend request only follows a write seen while busy
  a_r11_susp_busy: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> $past(wsm_busy && bus_wr));

  // R8: a sequence error raises status bit 1 and starts nothing
  a_r8_seq_err: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_err |=> (status[1] && !op_start));

  // R3: clear removes erase/program failure flags when no new failure arrives
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clear && !wsm_erase_fail && !wsm_prog_fail) |=> (status[5:4] == 2'b00));

  // R12: failure flags stay set until cleared
  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !ev_clear) |=> status[5]);

  // R11: at most one request kind per cycle
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_start, susp_req, resume_req}));

  // R10: no enable without a read
  a_r10_idle_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (rd_oe == 8'h00));

endmodule

bind flash_cmd_decoder fcd_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .pe_en         (pe_en),
  .bus_rd        (bus_rd),
  .wsm_busy      (wsm_busy),
  .wsm_erase_fail(wsm_erase_fail),
  .wsm_prog_fail (wsm_prog_fail),
  .rd_oe         (rd_oe),
  .op_start      (op_start),
  .susp_req      (susp_req),
  .resume_req    (resume_req),
  .ev_clear      (ev_clear),
  .ev_seq_err    (ev_seq_err),
  .status        (status)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  localparam int  AW      = 22;
  localparam time CLK_PER = 10ns;

  localparam logic [7:0] ARR = 8'hA5;
  localparam logic [7:0] IDV = 8'h89;
  localparam logic [7:0] QRV = 8'h51;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = 8'h00;
  logic          bus_rd = 1'b1;
  logic          pe_en = 1'b1;
  logic [7:0]    rd_data, rd_oe;
  logic          wsm_busy = 1'b0, wsm_susp = 1'b0;
  logic          wsm_erase_fail = 1'b0, wsm_prog_fail = 1'b0;
  logic          op_start, susp_req, resume_req;
  logic [2:0]    op_code;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_wdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  flash_cmd_decoder #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .pe_en(pe_en),
    .arr_rdata(ARR), .id_rdata(IDV), .qry_rdata(QRV),
    .rd_data(rd_data), .rd_oe(rd_oe), .wsm_busy(wsm_busy),
    .wsm_susp(wsm_susp), .wsm_erase_fail(wsm_erase_fail),
    .wsm_prog_fail(wsm_prog_fail), .op_start(op_start),
    .op_code(op_code), .op_addr(op_addr), .op_wdata(op_wdata),
    .susp_req(susp_req), .resume_req(resume_req)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one host write; returns at the falling edge after the capturing edge
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_start(input string req, input logic [2:0] code,
                              input logic [AW-1:0] a, input logic [7:0] d);
    check({req, " start"}, op_start, 1'b1);
    check({req, " code"},  op_code, code);
    check({req, " addr"},  op_addr, a);
    check({req, " data"},  op_wdata, d);
    @(negedge clk);
    check({req, " pulse width"}, op_start, 1'b0);
  endtask

  task automatic read_status(input string req, input logic [7:0] exp);
    wr('0, 8'h70);
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    check("R1 array after reset", rd_data, ARR);
    check("R1 start low", op_start, 1'b0);
    check("R1 req low", {susp_req, resume_req}, 2'b00);
    read_status("R1 status idle", 8'h80);
  endtask

  task automatic t_read_modes;
    wr('0, 8'h90); check("R2 ident", rd_data, IDV);
    wr('0, 8'h98); check("R2 query", rd_data, QRV);
    wr('0, 8'h70); check("R2 status", rd_data, 8'h80);
    wr('0, 8'hFF); check("R2 array", rd_data, ARR);
  endtask

  task automatic t_erase;
    wr('0, 8'h20);
    check("R4 no start on first", op_start, 1'b0);
    wr(22'h12345, 8'hD0);
    expect_start("R4", 3'd0, 22'h12345, 8'hD0);
    check("R4 status mode", rd_data, 8'h80);
  endtask

  task automatic t_program;
    wr('0, 8'h40); wr(22'h00ABC, 8'h3C);
    expect_start("R5 40h", 3'd1, 22'h00ABC, 8'h3C);
    wr('0, 8'h10); wr(22'h00123, 8'hFF);
    expect_start("R5 10h", 3'd1, 22'h00123, 8'hFF);
  endtask

  task automatic t_lock_branch;
    wr('0, 8'h60); wr(22'h04000, 8'h01);
    expect_start("R6 lock set", 3'd5, 22'h04000, 8'h01);
    wr('0, 8'h60); wr(22'h00000, 8'hD0);
    expect_start("R6 lock clear", 3'd6, 22'h00000, 8'hD0);
    wr('0, 8'h60); wr(22'h00077, 8'h03);
    expect_start("R6 read config", 3'd7, 22'h00077, 8'h03);
  endtask

  task automatic t_others;
    wr('0, 8'hE8); wr(22'h08000, 8'h1F);
    expect_start("R7 buffer", 3'd2, 22'h08000, 8'h1F);
    wr('0, 8'hC0); wr(22'h00081, 8'h55);
    expect_start("R7 protect", 3'd3, 22'h00081, 8'h55);
    wr('0, 8'hB8); wr(22'h00002, 8'h04);
    expect_start("R7 config", 3'd4, 22'h00002, 8'h04);
  endtask

  task automatic t_seq_err;
    wr('0, 8'hFF);
    wr('0, 8'h20); wr(22'h1, 8'h40);
    check("R8 no start erase", op_start, 1'b0);
    check("R8 bit1 set", rd_data, 8'h82);
    wr('0, 8'h50);
    check("R3 clear bit1", rd_data, 8'h80);
    wr('0, 8'hFF);
    wr('0, 8'h60); wr(22'h1, 8'hFF);
    check("R8 no start lock grp", op_start, 1'b0);
    check("R8 FFh as second byte", rd_data, 8'h82);
    wr('0, 8'h50);
  endtask

  task automatic t_lockout;
    pe_en = 1'b0;
    wr('0, 8'hFF);
    wr('0, 8'h40); wr(22'h5, 8'h77);
    check("R9 no start", op_start, 1'b0);
    check("R9 bit3 set", rd_data, 8'h88);
    wr('0, 8'h98);
    check("R9 query read in lockout", rd_data, QRV);
    wr('0, 8'h50);
    wr('0, 8'h70);
    check("R3 clear bit3", rd_data, 8'h80);
    pe_en = 1'b1;
  endtask

  task automatic t_busy;
    wsm_busy = 1'b1;
    @(negedge clk);
    check("R10 busy oe", rd_oe, 8'h80);
    check("R10 busy bit7", rd_data[7], 1'b0);
    check("R12 ready bit low", rd_data, 8'h00);
    bus_rd = 1'b0;
    @(negedge clk);
    check("R10 no read oe", rd_oe, 8'h00);
    bus_rd = 1'b1;
    wsm_busy = 1'b0;
    @(negedge clk);
    check("R10 idle oe", rd_oe, 8'hFF);
  endtask

  task automatic t_suspend;
    wr('0, 8'hB0);
    check("R11 no susp when idle", susp_req, 1'b0);
    wr('0, 8'hD0);
    check("R11 no resume when not suspended", resume_req, 1'b0);
    // last start was config (R7), so suspension appears as program bit
    wsm_susp = 1'b1;
    wr('0, 8'h70);
    check("R12 program suspended bit2", rd_data, 8'h84);
    wsm_susp = 1'b0;
    wr('0, 8'h20); wr(22'h2, 8'hD0);
    check("R4 erase start", op_start, 1'b1);
    wsm_busy = 1'b1;
    wr('0, 8'hFF);
    wr('0, 8'hB0);
    check("R11 susp pulse", susp_req, 1'b1);
    @(negedge clk);
    check("R11 susp one cycle", susp_req, 1'b0);
    wsm_busy = 1'b0; wsm_susp = 1'b1;
    @(negedge clk);
    check("R12 erase suspended bit6", rd_data, 8'hC0);
    wr('0, 8'hD0);
    check("R11 resume pulse", resume_req, 1'b1);
    check("R11 resume no start", op_start, 1'b0);
    @(negedge clk);
    check("R11 resume one cycle", resume_req, 1'b0);
    wsm_susp = 1'b0;
  endtask

  task automatic t_wsm_err;
    @(negedge clk);
    wsm_erase_fail = 1'b1;
    @(negedge clk);
    wsm_erase_fail = 1'b0;
    check("R12 erase fail bit5", rd_data, 8'hA0);
    wsm_prog_fail = 1'b1;
    @(negedge clk);
    wsm_prog_fail = 1'b0;
    check("R12 prog fail bit4", rd_data, 8'hB0);
    repeat (3) @(negedge clk);
    check("R12 flags sticky", rd_data, 8'hB0);
    // clear and new erase failure in the same cycle: failure wins
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 8'h50; wsm_erase_fail = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; wsm_erase_fail = 1'b0;
    check("R3 set wins over clear", rd_data, 8'hA0);
    wr('0, 8'h90);
    wr('0, 8'h50);
    check("R3 mode kept after clear", rd_data, IDV);
    read_status("R3 all cleared", 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_modes();
    t_erase();
    t_program();
    t_lock_branch();
    t_others();
    t_seq_err();
    t_lockout();
    t_busy();
    t_suspend();
    t_wsm_err();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule